// File: doc/BRIEF.md
# Rename-Aware Register State Transfer Engine

When a thread moves from an out-of-order execution engine to an in-order engine, its architectural registers must be copied from wherever the rename table currently places them in the large physical register file into the small flat register file of the in-order side. This block performs that copy. A start strobe marks every architectural register as pending. The engine then sends one pending register per cycle into a three-stage pipeline: rename-table lookup, physical register read, and destination write.

Commits on the out-of-order side may still retire while the copy is under way. A commit notification names the architectural register it updated. If that register has already entered the pipeline, or is being read there at that moment, it is marked pending again, so its newest value is copied later. The done flag rises only after nothing is pending and the pipeline has drained. It stays high until the next accepted start.

The rename-table and physical-register-file read ports expect data back combinationally in the same cycle as the address. Every output of the block comes from a register.

Top module: `rsx_transfer`

## Requirements
- R1: After an accepted start, each destination register a (0 to NUM_AREG-1) ends up holding the physical register value that the rename entry for a selects at the moment done rises. Commits that change the mapping or the value during the transfer are included.
- R2: Pending registers are sent lowest index first, one per cycle. Each register reaches the destination write port exactly three clock edges after it is sent. In a transfer with no commits, the first write is visible after the 3rd edge following the start edge, and registers 0 to 31 are written in ascending order on consecutive cycles.
- R3: A transfer with no commits performs exactly 32 destination writes. Done rises on the 36th clock edge after the edge that sampled start.
- R4: A commit naming a register that was sent on or before the edge that samples the commit causes exactly one extra write of that register. A commit naming a register not yet sent causes no extra write. With one such requeue during the initial scan, done rises at edge 37. A requeue sampled at edge n, where n is 33 or later, gives done at edge n+5.
- R5: Done is low while any register is pending or the pipeline holds a valid entry. Done stays high with no writes until the next accepted start.
- R6: A start strobe during a transfer is ignored. The transfer keeps its 32 writes and its done timing.
- R7: A commit notification while no transfer is running is ignored. It causes no write, and done stays high.
- R8: After synchronous reset, done, the destination write enable and both read enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| commit_valid | input | 1 | A commit updated an architectural register this cycle |
| commit_areg | input | AW | Architectural register updated by the commit |
| rat_re | output | 1 | Rename-table read enable |
| rat_addr | output | AW | Architectural register being looked up |
| rat_preg | input | PW | Physical register returned by the rename table, same cycle |
| prf_re | output | 1 | Physical register file read enable |
| prf_addr | output | PW | Physical register being read |
| prf_data | input | DATA_W | Physical register value, same cycle |
| dst_we | output | 1 | Destination register file write enable |
| dst_addr | output | AW | Destination register index |
| dst_data | output | DATA_W | Value written to the destination |
| done | output | 1 | Transfer complete |

## Verification
The assertions assume three things about the inputs. Commit notifications carry a register index below NUM_AREG. Start and commit are only meaningful when sampled on the clock. The rename table and physical file answer in the same cycle as the address.

The bench drives all inputs on the falling edge. It fires each commit for exactly one cycle, and it changes its own rename and register models in that same cycle. It remaps a committed register only into the upper half of the physical file, which no other register uses. Because of this, no other register's value changes while that register is in flight, and the expected contents stay well defined.

// File: rtl/rsx_pkg.sv
package rsx_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } rsx_state_e;
endpackage

// File: rtl/rsx_dirty_queue.sv
module rsx_dirty_queue #(
  parameter int NUM_AREG = 32,
  parameter int AW = $clog2(NUM_AREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          enable,
  input  logic          set_v,
  input  logic [AW-1:0] set_idx,
  output logic          issue_v,
  output logic [AW-1:0] issue_idx,
  output logic          any_pending
);
  logic [NUM_AREG-1:0] pend_q;
  logic                pick_v;
  logic [AW-1:0]       pick_idx;

  always_comb begin
    pick_v   = 1'b0;
    pick_idx = '0;
    for (int i = NUM_AREG - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        pick_v   = 1'b1;
        pick_idx = AW'(i);
      end
    end
  end

  assign issue_v     = enable && pick_v;
  assign issue_idx   = pick_idx;
  assign any_pending = pick_v;

  // One pending bit per architectural register; set beats clear.
  for (genvar g = 0; g < NUM_AREG; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        pend_q[g] <= 1'b0;
      else if (load)
        pend_q[g] <= 1'b1;
      else if (set_v && set_idx == AW'(g))
        pend_q[g] <= 1'b1;
      else if (issue_v && pick_idx == AW'(g))
        pend_q[g] <= 1'b0;
    end
  end

  assert_commit_requeues_R4: assert property (@(posedge clk) disable iff (rst)
    (set_v && !load) |=> pend_q[$past(set_idx)]);

  assert_lowest_first_R2: assert property (@(posedge clk) disable iff (rst)
    (issue_v && !load && !(set_v && set_idx == issue_idx)) |=> !pend_q[$past(issue_idx)]);
endmodule

// File: rtl/rsx_copy_pipe.sv
module rsx_copy_pipe #(
  parameter int NUM_AREG = 32,
  parameter int NUM_PREG = 128,
  parameter int DATA_W = 64,
  parameter int AW = $clog2(NUM_AREG),
  parameter int PW = $clog2(NUM_PREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_v,
  input  logic [AW-1:0]     in_areg,
  output logic              rat_re,
  output logic [AW-1:0]     rat_addr,
  input  logic [PW-1:0]     rat_preg,
  output logic              prf_re,
  output logic [PW-1:0]     prf_addr,
  input  logic [DATA_W-1:0] prf_data,
  output logic              dst_we,
  output logic [AW-1:0]     dst_addr,
  output logic [DATA_W-1:0] dst_data,
  output logic              empty
);
  logic              look_v, read_v, wr_v;
  logic [AW-1:0]     look_a, read_a, wr_a;
  logic [PW-1:0]     read_p;
  logic [DATA_W-1:0] wr_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      look_v <= 1'b0;
      read_v <= 1'b0;
      wr_v   <= 1'b0;
      look_a <= '0;
      read_a <= '0;
      read_p <= '0;
      wr_a   <= '0;
      wr_d   <= '0;
    end else begin
      look_v <= in_v;
      look_a <= in_areg;
      read_v <= look_v;
      read_a <= look_a;
      read_p <= rat_preg;
      wr_v   <= read_v;
      wr_a   <= read_a;
      wr_d   <= prf_data;
    end
  end

  assign rat_re   = look_v;
  assign rat_addr = look_a;
  assign prf_re   = read_v;
  assign prf_addr = read_p;
  assign dst_we   = wr_v;
  assign dst_addr = wr_a;
  assign dst_data = wr_d;
  assign empty    = !(look_v || read_v || wr_v);

  assert_three_stage_R2: assert property (@(posedge clk) disable iff (rst)
    in_v |=> ##2 (dst_we && dst_addr == $past(in_areg, 3)));
endmodule

// File: rtl/rsx_transfer.sv
module rsx_transfer
  import rsx_pkg::*;
#(
  parameter int NUM_AREG = 32,
  parameter int NUM_PREG = 128,
  parameter int DATA_W = 64,
  parameter int AW = $clog2(NUM_AREG),
  parameter int PW = $clog2(NUM_PREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              commit_valid,
  input  logic [AW-1:0]     commit_areg,
  output logic              rat_re,
  output logic [AW-1:0]     rat_addr,
  input  logic [PW-1:0]     rat_preg,
  output logic              prf_re,
  output logic [PW-1:0]     prf_addr,
  input  logic [DATA_W-1:0] prf_data,
  output logic              dst_we,
  output logic [AW-1:0]     dst_addr,
  output logic [DATA_W-1:0] dst_data,
  output logic              done
);
  rsx_state_e    state_q;
  logic          done_q;
  logic          start_acc, commit_hit, finish;
  logic          issue_v, any_pending, pipe_empty;
  logic [AW-1:0] issue_idx;

  assign start_acc  = start && state_q == ST_IDLE;
  assign commit_hit = commit_valid && state_q == ST_RUN;
  assign finish     = state_q == ST_RUN && !any_pending && pipe_empty && !commit_valid;

  rsx_dirty_queue #(.NUM_AREG(NUM_AREG), .AW(AW)) u_queue (
    .clk         (clk),
    .rst         (rst),
    .load        (start_acc),
    .enable      (state_q == ST_RUN),
    .set_v       (commit_hit),
    .set_idx     (commit_areg),
    .issue_v     (issue_v),
    .issue_idx   (issue_idx),
    .any_pending (any_pending)
  );

  rsx_copy_pipe #(
    .NUM_AREG(NUM_AREG), .NUM_PREG(NUM_PREG), .DATA_W(DATA_W), .AW(AW), .PW(PW)
  ) u_pipe (
    .clk      (clk),
    .rst      (rst),
    .in_v     (issue_v),
    .in_areg  (issue_idx),
    .rat_re   (rat_re),
    .rat_addr (rat_addr),
    .rat_preg (rat_preg),
    .prf_re   (prf_re),
    .prf_addr (prf_addr),
    .prf_data (prf_data),
    .dst_we   (dst_we),
    .dst_addr (dst_addr),
    .dst_data (dst_data),
    .empty    (pipe_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else if (start_acc) begin
      state_q <= ST_RUN;
      done_q  <= 1'b0;
    end else if (finish) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b1;
    end
  end

  assign done = done_q;

  assert_start_runs_R1: assert property (@(posedge clk) disable iff (rst)
    start_acc |=> (state_q == ST_RUN && !done));

  assert_done_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (!dst_we && !any_pending && pipe_empty));

  assert_busy_start_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (start && state_q == ST_RUN && !finish) |=> state_q == ST_RUN);

  assert_idle_commit_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !start) |=> (state_q == ST_IDLE && !any_pending));
endmodule

// File: tb/rsx_transfer_tb.sv
module rsx_transfer_tb;
  localparam int NA = 32;
  localparam int NP = 128;
  localparam int DW = 64;
  localparam int NVEC = 7;
  // [31:24] mul, [23:16] add, [15] commit enable, [12:8] commit reg, [7:0] commit delay
  localparam logic [31:0] VECS [NVEC] = '{
    {8'd1,  8'd0,  1'b0, 2'b0, 5'd0,  8'd0},
    {8'd5,  8'd17, 1'b0, 2'b0, 5'd0,  8'd0},
    {8'd3,  8'd9,  1'b1, 2'b0, 5'd4,  8'd10},
    {8'd7,  8'd1,  1'b1, 2'b0, 5'd20, 8'd5},
    {8'd9,  8'd3,  1'b1, 2'b0, 5'd31, 8'd33},
    {8'd11, 8'd40, 1'b1, 2'b0, 5'd12, 8'd12},
    {8'd13, 8'd2,  1'b1, 2'b0, 5'd31, 8'd34}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          commit_valid = 1'b0;
  logic [4:0]    commit_areg = '0;
  logic          rat_re, prf_re, dst_we, done;
  logic [4:0]    rat_addr, dst_addr;
  logic [6:0]    rat_preg, prf_addr;
  logic [DW-1:0] prf_data, dst_data;

  logic [6:0]    rat_mem [NA];
  logic [DW-1:0] prf_mem [NP];
  logic [DW-1:0] shadow  [NA];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign rat_preg = rat_mem[rat_addr];
  assign prf_data = prf_mem[prf_addr];

  rsx_transfer u_dut (
    .clk(clk), .rst(rst), .start(start), .commit_valid(commit_valid),
    .commit_areg(commit_areg), .rat_re(rat_re), .rat_addr(rat_addr),
    .rat_preg(rat_preg), .prf_re(prf_re), .prf_addr(prf_addr),
    .prf_data(prf_data), .dst_we(dst_we), .dst_addr(dst_addr),
    .dst_data(dst_data), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic fire_commit(input int r);
    commit_valid = 1'b1;
    commit_areg  = 5'(r);
    rat_mem[r]   = rat_mem[r] + 7'd64;
    prf_mem[rat_mem[r]] = ~prf_mem[rat_mem[r]] ^ DW'(r);
  endtask

  task automatic run_xfer(input bit cen, input int creg, input int cdly, input int sbk,
                          output int done_k, output int nwr, output int first_k,
                          output bit in_order);
    nwr = 0; first_k = -1; in_order = 1; done_k = -1;
    @(negedge clk) start = 1'b1;
    @(posedge clk);
    @(negedge clk) start = 1'b0;
    if (cen && cdly == 0) fire_commit(creg);
    for (int k = 1; k <= 200; k++) begin
      @(posedge clk);
      @(negedge clk);
      commit_valid = 1'b0;
      start = 1'b0;
      if (dst_we) begin
        shadow[dst_addr] = dst_data;
        if (first_k < 0) first_k = k;
        if (int'(dst_addr) != nwr) in_order = 0;
        nwr++;
      end
      if (done) begin
        done_k = k;
        break;
      end
      if (cen && k == cdly) fire_commit(creg);
      if (sbk != 0 && k == sbk) start = 1'b1;
    end
  endtask

  task automatic fill(input int mul, input int add, input int seed);
    for (int p = 0; p < NP; p++)
      prf_mem[p] = {32'(p) * 32'h9E3779B1 ^ 32'(seed), 32'(p) ^ ~32'(seed)};
    for (int i = 0; i < NA; i++) begin
      rat_mem[i] = 7'((i * mul + add) % 64);
      shadow[i]  = '0;
    end
  endtask

  function automatic int count_bad();
    int bad = 0;
    for (int i = 0; i < NA; i++)
      if (shadow[i] !== prf_mem[rat_mem[i]]) bad++;
    return bad;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int dk, nw, fk, extra, exp_done;
    bit ord;
    fill(1, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R8: reset state
    chk(done == 1'b0, "R8", "done after reset", done, 0);
    chk(dst_we == 1'b0, "R8", "dst_we after reset", dst_we, 0);
    chk(rat_re == 1'b0 && prf_re == 1'b0, "R8", "read enables after reset", {rat_re, prf_re}, 0);

    for (int v = 0; v < NVEC; v++) begin
      automatic int mul  = int'(VECS[v][31:24]);
      automatic int add  = int'(VECS[v][23:16]);
      automatic bit cen  = VECS[v][15];
      automatic int creg = int'(VECS[v][12:8]);
      automatic int cd   = int'(VECS[v][7:0]);
      fill(mul, add, v * 7 + 3);
      run_xfer(cen, creg, cd, 0, dk, nw, fk, ord);
      extra = (cen && creg <= cd) ? 1 : 0;
      if (extra == 0) exp_done = 36;
      else if (cd <= 31) exp_done = 37;
      else exp_done = cd + 6;
      chk(count_bad() == 0, "R1", $sformatf("vec %0d mismatched registers", v), count_bad(), 0);
      chk(nw == 32 + extra, extra ? "R4" : "R3", $sformatf("vec %0d write count", v), nw, 32 + extra);
      chk(dk == exp_done, extra ? "R4" : "R3", $sformatf("vec %0d done edge", v), dk, exp_done);
      if (!cen) begin
        chk(ord, "R2", $sformatf("vec %0d ascending order", v), ord, 1);
        chk(fk == 3, "R2", $sformatf("vec %0d first write edge", v), fk, 3);
      end
    end

    // R5: done holds with no writes until next start
    begin
      bit quiet = 1;
      repeat (6) begin
        @(negedge clk);
        if (!done || dst_we) quiet = 0;
      end
      chk(quiet, "R5", "done held, no writes while idle", quiet, 1);
    end

    // R7: commits while idle are ignored
    begin
      bit quiet = 1;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        commit_valid = 1'b1;
        commit_areg  = 5'(i * 3);
        if (!done || dst_we) quiet = 0;
      end
      @(negedge clk) commit_valid = 1'b0;
      repeat (5) begin
        @(negedge clk);
        if (!done || dst_we) quiet = 0;
      end
      chk(quiet, "R7", "idle commits caused no write", quiet, 1);
    end

    // R6: start while busy is ignored
    fill(15, 5, 99);
    run_xfer(1'b0, 0, 0, 10, dk, nw, fk, ord);
    chk(nw == 32, "R6", "writes with start while busy", nw, 32);
    chk(dk == 36, "R6", "done edge with start while busy", dk, 36);
    chk(count_bad() == 0, "R1", "values after busy start", count_bad(), 0);

    // R8: reset mid-transfer clears outputs
    fill(3, 1, 5);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (6) @(negedge clk);
    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk(!done && !dst_we && !rat_re && !prf_re, "R8", "outputs after mid-run reset",
        {done, dst_we, rat_re, prf_re}, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule